// File: doc/BRIEF.md
# Memory Range Pattern Fill Engine

This engine writes a chosen data pattern over a contiguous word range of a memory and can read the range back to compare it against that pattern. Once software has set the bounds, the pattern and the mode, and then pulsed start, the engine works through the range on its own. The host processor is free to do other configuration work while it runs. The engine can be used to bring memory to a known state, to run a quick limited memory test, or to clear a region to zero.

Each pattern is a pair of complementary nibbles. The first nibble of the pair is copied across every word at an even address. Its complement is copied across every word at an odd address. A verify pass expects the same layout. The memory side is a simple synchronous request port. A write completes in the cycle it is issued. A read is answered by a valid strobe some cycles later, and only one read is ever outstanding.

Top module: `patfill_engine`

## Requirements
- R1: After reset, busy, done, err_mismatch and err_cfg are 0, and neither mem_we nor mem_re is asserted.
- R2: In fill mode (cfg_mode 2'b00), the engine writes one word per cycle at ascending addresses from the start address to the end address inclusive. A word at an even address holds nibble X in every nibble position, and a word at an odd address holds ~X. For cfg_pattern 2'b00, 2'b01, 2'b10 and 2'b11, X is 0x0, 0xA, 0x3 and 0x6 respectively.
- R3: In zero mode (cfg_mode 2'b11), every word in the range is written with 0, whatever the value of cfg_pattern.
- R4: In verify mode (cfg_mode 2'b01), the engine issues no writes. For each address in ascending order, it raises mem_re for exactly one cycle and then waits for mem_rvalid before it issues the next read.
- R5: The first read word that differs from the expected pattern sets err_mismatch and records its address in err_addr. Both stay unchanged until the next start is accepted, and later mismatches do not change them.
- R6: A mismatch does not stop the scan, which runs to the end address. When a run finishes, done is high for exactly the one cycle in which busy first reads 0.
- R7: In fill-then-verify mode (cfg_mode 2'b10), the engine performs a complete fill pass and then a verify pass over the same range, with one done pulse at the end.
- R8: A start pulse while busy is high is ignored. The run in progress continues with its original settings.
- R9: A start while idle with the end address below the start address sets err_cfg. In that case the engine performs no memory access and does not become busy.
- R10: A start accepted while idle clears err_mismatch and err_cfg. A valid run leaves err_cfg at 0.
- R11: mem_we and mem_re are never high together, and either one is high only while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start_addr | input | ADDR_W | First word address of the range |
| cfg_end_addr | input | ADDR_W | Last word address of the range (inclusive) |
| cfg_pattern | input | 2 | Pattern pair select |
| cfg_mode | input | 2 | 00 fill, 01 verify, 10 fill then verify, 11 zero |
| cmd_start | input | 1 | Start request, sampled while idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| err_mismatch | output | 1 | Sticky verify mismatch flag |
| err_addr | output | ADDR_W | Address of the first mismatching word |
| err_cfg | output | 1 | Range was invalid at the last start |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read request |
| mem_rdata | input | DATA_W | Memory read data |
| mem_rvalid | input | 1 | Read data valid |

## Verification
The properties assume that the memory raises mem_rvalid only in answer to an outstanding read. They also assume that cmd_start is driven cleanly between clock edges. The stimulus memory model answers every read exactly one cycle after the request and never sends an unrequested strobe. Start pulses come only from negative-edge driven tasks, including the deliberate pulses sent while busy. Mismatches are created by changing words in the memory model between runs, never while the engine is reading.

// File: rtl/patfill_pkg.sv
package patfill_pkg;

    typedef enum logic [1:0] {
        MODE_FILL        = 2'b00,
        MODE_VERIFY      = 2'b01,
        MODE_FILL_VERIFY = 2'b10,
        MODE_ZERO        = 2'b11
    } pf_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_WRITE   = 2'b01,
        ST_RD_REQ  = 2'b10,
        ST_RD_WAIT = 2'b11
    } pf_state_e;

    // nibble used on even addresses; odd addresses take its complement
    function automatic logic [3:0] pf_even_nibble(input logic [1:0] sel);
        logic [3:0] n;
        case (sel)
            2'b00:   n = 4'h0;
            2'b01:   n = 4'hA;
            2'b10:   n = 4'h3;
            default: n = 4'h6;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/patfill_pattern.sv
module patfill_pattern #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        sel_i,
    input  logic              zero_i,
    input  logic              odd_i,
    output logic [DATA_W-1:0] data_o
);
    import patfill_pkg::*;

    localparam int NIBS = DATA_W / 4;

    logic [3:0] nib;

    always_comb begin
        if (zero_i) begin
            nib = 4'h0;
        end else if (odd_i) begin
            nib = ~pf_even_nibble(sel_i);
        end else begin
            nib = pf_even_nibble(sel_i);
        end
    end

    generate
        for (genvar g = 0; g < NIBS; g++) begin : g_rep
            assign data_o[4*g +: 4] = nib;
        end
    endgenerate

endmodule

// File: rtl/patfill_seq.sv
module patfill_seq #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_start_addr,
    input  logic [ADDR_W-1:0] cfg_end_addr,
    input  logic [1:0]        cfg_pattern,
    input  logic [1:0]        cfg_mode,
    input  logic              cmd_start,
    input  logic              mem_rvalid,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        sel_o,
    output logic              zero_o,
    output logic              we_o,
    output logic              re_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              cfg_err_o,
    output logic              clear_o,
    output logic              check_o
);
    import patfill_pkg::*;

    typedef struct packed {
        pf_state_e         state;
        pf_mode_e          mode;
        logic [1:0]        sel;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] first;
        logic [ADDR_W-1:0] last;
        logic              done;
        logic              cfg_err;
    } seq_t;

    seq_t seq_d, seq_q;
    logic at_last;

    assign at_last = (seq_q.addr == seq_q.last);

    always_comb begin
        seq_d   = seq_q;
        seq_d.done = 1'b0;
        clear_o = 1'b0;
        check_o = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (cmd_start) begin
                    clear_o = 1'b1;
                    if (cfg_end_addr < cfg_start_addr) begin
                        seq_d.cfg_err = 1'b1;
                    end else begin
                        seq_d.cfg_err = 1'b0;
                        seq_d.mode    = pf_mode_e'(cfg_mode);
                        seq_d.sel     = cfg_pattern;
                        seq_d.first   = cfg_start_addr;
                        seq_d.last    = cfg_end_addr;
                        seq_d.addr    = cfg_start_addr;
                        seq_d.state   = (pf_mode_e'(cfg_mode) == MODE_VERIFY) ? ST_RD_REQ : ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (at_last) begin
                    if (seq_q.mode == MODE_FILL_VERIFY) begin
                        seq_d.state = ST_RD_REQ;
                        seq_d.addr  = seq_q.first;
                    end else begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                    end
                end else begin
                    seq_d.addr = seq_q.addr + 1'b1;
                end
            end
            ST_RD_REQ: begin
                seq_d.state = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (mem_rvalid) begin
                    check_o = 1'b1;
                    if (at_last) begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.addr  = seq_q.addr + 1'b1;
                        seq_d.state = ST_RD_REQ;
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, mode: MODE_FILL, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign addr_o    = seq_q.addr;
    assign sel_o     = seq_q.sel;
    assign zero_o    = (seq_q.mode == MODE_ZERO);
    assign we_o      = (seq_q.state == ST_WRITE);
    assign re_o      = (seq_q.state == ST_RD_REQ);
    assign busy_o    = (seq_q.state != ST_IDLE);
    assign done_o    = seq_q.done;
    assign cfg_err_o = seq_q.cfg_err;

endmodule

// File: rtl/patfill_cmp.sv
module patfill_cmp #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              check_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] expect_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              err_o,
    output logic [ADDR_W-1:0] err_addr_o
);
    typedef struct packed {
        logic              err;
        logic [ADDR_W-1:0] addr;
    } cmp_t;

    cmp_t cmp_d, cmp_q;

    always_comb begin
        cmp_d = cmp_q;
        if (clear_i) begin
            cmp_d = '0;
        end else if (check_i && (rdata_i != expect_i) && !cmp_q.err) begin
            cmp_d.err  = 1'b1;
            cmp_d.addr = addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else begin
            cmp_q <= cmp_d;
        end
    end

    assign err_o      = cmp_q.err;
    assign err_addr_o = cmp_q.addr;

endmodule

// File: rtl/patfill_engine.sv
module patfill_engine #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_start_addr,
    input  logic [ADDR_W-1:0] cfg_end_addr,
    input  logic [1:0]        cfg_pattern,
    input  logic [1:0]        cfg_mode,
    input  logic              cmd_start,
    output logic              busy,
    output logic              done,
    output logic              err_mismatch,
    output logic [ADDR_W-1:0] err_addr,
    output logic              err_cfg,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid
);
    logic [ADDR_W-1:0] cur_addr;
    logic [1:0]        cur_sel;
    logic              cur_zero;
    logic              clear;
    logic              check;
    logic [DATA_W-1:0] pat_word;

    patfill_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_start_addr (cfg_start_addr),
        .cfg_end_addr   (cfg_end_addr),
        .cfg_pattern    (cfg_pattern),
        .cfg_mode       (cfg_mode),
        .cmd_start      (cmd_start),
        .mem_rvalid     (mem_rvalid),
        .addr_o         (cur_addr),
        .sel_o          (cur_sel),
        .zero_o         (cur_zero),
        .we_o           (mem_we),
        .re_o           (mem_re),
        .busy_o         (busy),
        .done_o         (done),
        .cfg_err_o      (err_cfg),
        .clear_o        (clear),
        .check_o        (check)
    );

    patfill_pattern #(.DATA_W(DATA_W)) pat_i (
        .sel_i  (cur_sel),
        .zero_i (cur_zero),
        .odd_i  (cur_addr[0]),
        .data_o (pat_word)
    );

    patfill_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cmp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .check_i    (check),
        .addr_i     (cur_addr),
        .expect_i   (pat_word),
        .rdata_i    (mem_rdata),
        .err_o      (err_mismatch),
        .err_addr_o (err_addr)
    );

    assign mem_addr  = cur_addr;
    assign mem_wdata = pat_word;

endmodule

// File: rtl/patfill_engine_chk.sv
module patfill_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_start,
    input logic              busy,
    input logic              done,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              err_mismatch,
    input logic [ADDR_W-1:0] err_addr,
    input logic              err_cfg
);
    // R11
    we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R11
    access_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> busy);

    // R2
    write_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (!mem_we || mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    // R4
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re);

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_mismatch && !(cmd_start && !busy)) |=> err_mismatch);

    // R5
    err_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_mismatch && !(cmd_start && !busy)) |=> $stable(err_addr));

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    cfg_err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_cfg) |-> !busy);

endmodule

bind patfill_engine patfill_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_start    (cmd_start),
    .busy         (busy),
    .done         (done),
    .mem_we       (mem_we),
    .mem_re       (mem_re),
    .mem_addr     (mem_addr),
    .err_mismatch (err_mismatch),
    .err_addr     (err_addr),
    .err_cfg      (err_cfg)
);

// File: tb/patfill_engine_tb_top.sv
module patfill_engine_tb_top;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_start_addr = '0;
    logic [AW-1:0] cfg_end_addr = '0;
    logic [1:0]    cfg_pattern = '0;
    logic [1:0]    cfg_mode = '0;
    logic          cmd_start = 1'b0;
    logic          busy, done, err_mismatch, err_cfg, mem_we, mem_re;
    logic [AW-1:0] err_addr, mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_rvalid = 1'b0;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;
    string cur_tag = "R1";

    typedef struct {
        bit          we;
        bit          re;
        bit          bsy;
        bit          dn;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } exp_t;

    exp_t exp_q[$];
    bit [DW-1:0] mem [int];

    always #2.5 clk = ~clk;

    patfill_engine #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_start_addr(cfg_start_addr), .cfg_end_addr(cfg_end_addr),
        .cfg_pattern(cfg_pattern), .cfg_mode(cfg_mode), .cmd_start(cmd_start),
        .busy(busy), .done(done), .err_mismatch(err_mismatch), .err_addr(err_addr),
        .err_cfg(err_cfg), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
    );

    // memory model: reads answered one cycle after the request
    always @(posedge clk) begin
        mem_rvalid <= mem_re;
        if (mem_re) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : '0;
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    end

    function automatic logic [DW-1:0] pat(int a, int sel, bit zero);
        logic [3:0] x;
        logic [DW-1:0] w;
        case (sel)
            0: x = 4'h0;
            1: x = 4'hA;
            2: x = 4'h3;
            default: x = 4'h6;
        endcase
        if (a % 2 == 1) x = ~x;
        if (zero) x = 4'h0;
        for (int i = 0; i < DW/4; i++) w[4*i +: 4] = x;
        return w;
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // per-cycle comparison, sampled 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (model_on) begin
                exp_t e;
                logic [DW+AW+3:0] act_v, exp_v;
                if (exp_q.size() != 0) e = exp_q.pop_front();
                else e = '{we:0, re:0, bsy:0, dn:0, addr:'0, data:'0};
                exp_v = {e.we, e.re, e.bsy, e.dn,
                         (e.we || e.re) ? e.addr : {AW{1'b0}}, e.we ? e.data : {DW{1'b0}}};
                act_v = {mem_we, mem_re, busy, done,
                         (mem_we || mem_re) ? mem_addr : {AW{1'b0}}, mem_we ? mem_wdata : {DW{1'b0}}};
                chk(act_v === exp_v, cur_tag, "cycle {we,re,busy,done,addr,data}", act_v, exp_v);
            end
        end
    end

    // runs one command; poke sends a second start with other settings mid-run
    task automatic run(int s, int e, int sel, int mode, bit poke, string tag);
        @(negedge clk);
        cur_tag = tag;
        cfg_start_addr = AW'(s);
        cfg_end_addr   = AW'(e);
        cfg_pattern    = 2'(sel);
        cfg_mode       = 2'(mode);
        if (mode != 1) begin
            for (int a = s; a <= e; a++)
                exp_q.push_back('{we:1, re:0, bsy:1, dn:0, addr:AW'(a), data:pat(a, sel, mode == 3)});
        end
        if (mode == 1 || mode == 2) begin
            for (int a = s; a <= e; a++) begin
                exp_q.push_back('{we:0, re:1, bsy:1, dn:0, addr:AW'(a), data:'0});
                exp_q.push_back('{we:0, re:0, bsy:1, dn:0, addr:'0, data:'0});
            end
        end
        exp_q.push_back('{we:0, re:0, bsy:0, dn:1, addr:'0, data:'0});
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            cfg_start_addr = 16'h0900;
            cfg_end_addr   = 16'h0905;
            cfg_mode       = 2'b11;
            cfg_pattern    = 2'b10;
            cmd_start      = 1'b1;
            @(negedge clk);
            cmd_start      = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int first_bad(int s, int e, int sel);
        for (int a = s; a <= e; a++) begin
            bit [DW-1:0] v;
            v = mem.exists(a) ? mem[a] : '0;
            if (v != pat(a, sel, 1'b0)) return a;
        end
        return -1;
    endfunction

    task automatic verify_run(int s, int e, int sel, string tag);
        int fb;
        fb = first_bad(s, e, sel);
        run(s, e, sel, 1, 1'b0, tag);
        chk(err_mismatch == (fb >= 0), tag, "err_mismatch", err_mismatch, fb >= 0);
        if (fb >= 0) chk(err_addr == AW'(fb), tag, "err_addr", err_addr, fb);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !err_mismatch && !err_cfg && !mem_we && !mem_re, "R1", "reset outputs",
            {busy, done, err_mismatch, err_cfg, mem_we, mem_re}, 0);
        model_on = 1'b1;

        // R2 each pattern, odd start, single word
        run(16'h0010, 16'h0017, 0, 0, 1'b0, "R2 pattern 0/F");
        run(16'h0021, 16'h0028, 1, 0, 1'b0, "R2 pattern A/5");
        run(16'h0030, 16'h0036, 2, 0, 1'b0, "R2 pattern 3/C");
        run(16'h0041, 16'h0041, 3, 0, 1'b0, "R2 single word 6/9");
        run(16'hFFFC, 16'hFFFF, 3, 0, 1'b0, "R2 top of address space");

        // R4 clean verify
        verify_run(16'h0010, 16'h0017, 0, "R4 clean verify");
        // R5 R6 two faults: first kept, scan continues
        mem[16'h0022] ^= 32'h0000_0100;
        mem[16'h0026] ^= 32'h8000_0000;
        verify_run(16'h0021, 16'h0028, 1, "R5 R6 verify with faults");
        chk(err_mismatch === 1'b1, "R5", "flag still held while idle", err_mismatch, 1);

        // R10 accepted start clears the mismatch flag
        run(16'h0050, 16'h0053, 2, 0, 1'b0, "R10 fresh fill clears flags");
        chk(err_mismatch === 1'b0, "R10", "err_mismatch after new start", err_mismatch, 0);

        // R7 fill then verify, including previously corrupted words
        run(16'h0020, 16'h002A, 2, 2, 1'b0, "R7 fill then verify");
        chk(err_mismatch === 1'b0, "R7", "no mismatch after fill-verify", err_mismatch, 0);

        // R3 zero mode ignores pattern select
        run(16'h0060, 16'h0065, 1, 3, 1'b0, "R3 zero fill pattern 1");
        for (int a = 16'h0060; a <= 16'h0065; a++)
            chk(mem[a] == '0, "R3", "memory word zero", mem[a], 0);

        // R8 start while busy ignored
        run(16'h0070, 16'h007B, 0, 0, 1'b1, "R8 start while busy");
        chk(!mem.exists(16'h0900), "R8", "no write from ignored start", mem.exists(16'h0900), 0);

        // R9 invalid range
        @(negedge clk);
        cur_tag = "R9 invalid range";
        cfg_start_addr = 16'h0080;
        cfg_end_addr   = 16'h007F;
        cfg_mode       = 2'b00;
        cmd_start      = 1'b1;
        @(negedge clk);
        cmd_start      = 1'b0;
        chk(err_cfg === 1'b1, "R9", "err_cfg", err_cfg, 1);
        repeat (3) @(negedge clk);
        chk(!mem.exists(16'h0080) && !mem.exists(16'h007F), "R9", "no access", 1, 0);

        // R10 valid start clears err_cfg
        run(16'h0080, 16'h0081, 3, 0, 1'b0, "R10 clear cfg error");
        chk(err_cfg === 1'b0, "R10", "err_cfg after valid run", err_cfg, 0);

        // R11 covered by per-cycle we/re comparison across all runs above
        verify_run(16'h0070, 16'h007B, 0, "R11 verify after fill");

        model_on = 1'b0;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule